// File: doc/BRIEF.md
# Log-Response Successive-Approximation Converter Controller

This block is the digital sequencer of a successive-approximation converter whose output codes are spaced unevenly. Small inputs get fine steps and large inputs get coarse ones, so the transfer curve is a piecewise-linear approximation of a logarithm. Each bit trial passes the current trial code through a code-to-reference mapping before it is driven to the reference DAC. The search therefore lands directly on the compressed code. No lookup is needed after the conversion.

A single-cycle start pulse in the idle state opens a conversion. The block raises a sample strobe for one cycle so that the external sample-and-hold can capture the input. It then spends one cycle per output bit, from the MSB down. In each of those cycles it presents the mapped reference and reads the external comparator's greater-or-equal decision at the end of the cycle. When the last bit is decided it raises a one-cycle done pulse and updates the result register.

A mode input selects either the log-like table or a plain linear reference. The mode is captured together with the start pulse.

Top module: `nlsar_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `sample_o` are 0, `code_o` is 0 and `dac_ref_o` is 0. `dac_ref_o` is 0 at every cycle in which no bit decision is in progress.
- R2: A start pulse seen at a clock edge while idle makes `sample_o` and `busy_o` 1 for the next cycle. `sample_o` is high for exactly one cycle per conversion.
- R3: A conversion occupies CODE_W+1 cycles: one sample cycle, then CODE_W decision cycles. `done_o` is a one-cycle pulse in the cycle after the last decision, and `busy_o` is 0 in that cycle.
- R4: The first trial code has only the MSB set. When `cmp_ge_i` is 1 at the end of a decision cycle, the bit under test stays 1; otherwise it is cleared. The next lower bit is then set for the following trial.
- R5: In log mode (`log_mode_i`=1) the reference for trial code c is the sum of the code ranges of all codes below c. For CODE_W=8 the ranges are: 1 for codes 0-53, 2 for 54-101, 3 for 102-133, 4 for 134-157, 5 for 158-187, 6 for 188-203, 7 for 204-219, 8 for 220-231, 9 for 232-243 and 10 for 244-255. The ranges sum to 1024, the reference for code 128 is 228, and the reference for code 255 is 1014.
- R6: In linear mode (`log_mode_i`=0) the reference is the trial code shifted left by REF_W-CODE_W bits, padded with zeros. For CODE_W=8 the first reference is 512.
- R7: `log_mode_i` is captured at the accepted start pulse. Changes to it during a conversion do not affect that conversion.
- R8: A start pulse while `busy_o` is 1 is ignored: it produces no extra sample cycle and no extra done pulse.
- R9: `code_o` changes only in the cycle where `done_o` is 1. Between done pulses it holds its value, including during a following conversion.
- R10: Given an ideal comparator, the result is the largest code c whose reference is at or below the held input. In linear mode with CODE_W=8 this is the input divided by 4.
- R11: With CODE_W=2 and REF_W=3 the log table is {0,1,2,4}. For an input of 3.2 reference steps the trial 2 is kept and the trial 3 is rejected, giving the result 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only while idle |
| log_mode_i | input | 1 | 1 selects the log table, 0 selects the linear reference |
| cmp_ge_i | input | 1 | Comparator decision: held input >= reference |
| sample_o | output | 1 | Sample-and-hold strobe, one cycle per conversion |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| code_o | output | CODE_W | Result code, held between done pulses |
| dac_ref_o | output | REF_W | Reference code for the DAC |

## Verification
The bench traces the reference sequence cycle by cycle for a log-mode input and a linear-mode input. It also drives an input that equals a reference exactly. A design that compared with strict greater-than, or that set the lower trial bit before deciding the current one, would show a different trace and a final code off by one.

The edges of the table are exercised: code 0, the segment boundaries at 53/54, 127/128 and full scale. An off-by-one in the cumulative sum would shift these results.

Further stimulus flips the mode and pulses start in the middle of a conversion. A design that read the mode live would mix the two references. A design that accepted a second start would emit a second done pulse that the scoreboard has not been told to expect.

Finally, the small 2-bit instance replays the 3.2-step example. A wrong keep/clear rule there gives 3 instead of 2.

// File: rtl/nlsar_pkg.sv
package nlsar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } nlsar_state_e;

   localparam int unsigned NUM_SEG = 10;

   // upper code bound of each range segment, for an 8-bit code space
   localparam int unsigned SEG_END [NUM_SEG] =
      '{54, 102, 134, 158, 188, 204, 220, 232, 244, 256};

   // reference for code c: sum of the code ranges of all codes below c
   function automatic int unsigned log_cum(int unsigned c, int unsigned cw);
      int unsigned acc;
      int unsigned lo;
      int unsigned hi;
      int unsigned top;
      acc = 0;
      lo  = 0;
      if (cw < 8) begin
         return (c == 0) ? 0 : (1 << (c - 1));
      end
      for (int unsigned k = 0; k < NUM_SEG; k++) begin
         hi = SEG_END[k] << (cw - 8);
         if (c > lo) begin
            top = (c < hi) ? c : hi;
            acc += (k + 1) * (top - lo);
         end
         lo = hi;
      end
      return acc;
   endfunction

endpackage

// File: rtl/nlsar_ref_map.sv
module nlsar_ref_map #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned REF_W  = 10
) (
   input  logic              log_mode_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [REF_W-1:0]  ref_o
);
   import nlsar_pkg::*;

   localparam int unsigned DEPTH = 1 << CODE_W;
   localparam int unsigned PAD_W = REF_W - CODE_W;

   logic [REF_W-1:0] log_tbl [DEPTH];
   logic [REF_W-1:0] lin_ref;

   for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      assign log_tbl[i] = REF_W'(log_cum(i, CODE_W));
   end

   assign lin_ref = {code_i, {PAD_W{1'b0}}};
   assign ref_o   = log_mode_i ? log_tbl[code_i] : lin_ref;

endmodule

// File: rtl/nlsar_seq.sv
module nlsar_seq #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              log_mode_i,
   input  logic              cmp_ge_i,
   output logic              sample_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              conv_o,
   output logic              mode_q_o,
   output logic [CODE_W-1:0] trial_o,
   output logic [CODE_W-1:0] code_o
);
   import nlsar_pkg::*;

   localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);
   localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

   nlsar_state_e      state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CODE_W-1:0] sar_q;
   logic [CODE_W-1:0] res_q;
   logic              done_q;
   logic              mode_q;

   logic [CODE_W-1:0] bit_sel;
   logic [CODE_W-1:0] low_sel;
   logic [CODE_W-1:0] decided;
   logic [CODE_W-1:0] next_trial;

   always_comb begin
      bit_sel    = CODE_W'(1) << idx_q;
      low_sel    = (idx_q == '0) ? '0 : (bit_sel >> 1);
      decided    = cmp_ge_i ? sar_q : (sar_q & ~bit_sel);
      next_trial = decided | low_sel;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         sar_q   <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SAMPLE;
                  mode_q  <= log_mode_i;
               end
            end
            ST_SAMPLE: begin
               state_q <= ST_CONV;
               sar_q   <= MSB_ONLY;
               idx_q   <= TOP_IDX;
            end
            ST_CONV: begin
               sar_q <= next_trial;
               if (idx_q == '0) begin
                  state_q <= ST_IDLE;
                  res_q   <= decided;
                  done_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sample_o = (state_q == ST_SAMPLE);
   assign conv_o   = (state_q == ST_CONV);
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign mode_q_o = mode_q;
   assign trial_o  = sar_q;
   assign code_o   = res_q;

   // R3: done lasts one cycle
   a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R3: leaving busy coincides with the done pulse
   a_r3_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);
   // R2: sample is one cycle and is followed by decisions
   a_r2_sample_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o |=> (conv_o && !sample_o));
   // R4: first trial holds only the MSB
   a_r4_first_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o |=> (trial_o == MSB_ONLY));
   // R8: no new sample cycle once a conversion is under way
   a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |=> !sample_o);
   // R9: result only moves with done
   a_r9_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(code_o));
   // R7: captured mode stays put through the conversion
   a_r7_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |-> $stable(mode_q_o));

endmodule

// File: rtl/nlsar_ctrl.sv
module nlsar_ctrl #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned REF_W  = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              log_mode_i,
   input  logic              cmp_ge_i,
   output logic              sample_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CODE_W-1:0] code_o,
   output logic [REF_W-1:0]  dac_ref_o
);
   localparam int unsigned WANT_REF_W = (CODE_W == 2) ? 3 : CODE_W + 2;
   localparam int unsigned PAD_W      = REF_W - CODE_W;

   if (!(CODE_W == 2 || (CODE_W >= 8 && CODE_W <= 12))) begin : g_bad_code_w
      $error("nlsar_ctrl: CODE_W must be 2 or 8..12");
   end
   if (REF_W != WANT_REF_W) begin : g_bad_ref_w
      $error("nlsar_ctrl: REF_W does not match the range schedule of CODE_W");
   end

   logic              conv;
   logic              mode_q;
   logic [CODE_W-1:0] trial;
   logic [REF_W-1:0]  map_ref;

   nlsar_seq #(.CODE_W(CODE_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .log_mode_i (log_mode_i),
      .cmp_ge_i   (cmp_ge_i),
      .sample_o   (sample_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .conv_o     (conv),
      .mode_q_o   (mode_q),
      .trial_o    (trial),
      .code_o     (code_o)
   );

   nlsar_ref_map #(.CODE_W(CODE_W), .REF_W(REF_W)) u_map (
      .log_mode_i (mode_q),
      .code_i     (trial),
      .ref_o      (map_ref)
   );

   assign dac_ref_o = conv ? map_ref : '0;

   // R1: no reference outside decision cycles
   a_r1_ref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (dac_ref_o == '0));
   // R6: linear references carry zero padding bits
   a_r6_lin_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !sample_o && !mode_q) |-> (dac_ref_o[PAD_W-1:0] == '0));

endmodule

// File: tb/nlsar_ctrl_tb.sv
module nlsar_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       start = 1'b0;
   logic       log_mode = 1'b0;
   logic       sample, busy, done;
   logic [7:0] code;
   logic [9:0] dac_ref;
   logic       cmp;
   int         vin_ana = 0;
   int         held = 0;

   nlsar_ctrl #(.CODE_W(8), .REF_W(10)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .log_mode_i(log_mode),
      .cmp_ge_i(cmp), .sample_o(sample), .busy_o(busy), .done_o(done),
      .code_o(code), .dac_ref_o(dac_ref));

   always @(posedge clk) if (sample) held <= vin_ana;
   assign cmp = (held >= int'(dac_ref));

   // small 2-bit instance, input in tenths of a reference step
   logic       s_start = 1'b0;
   logic       s_sample, s_busy, s_done;
   logic [1:0] s_code;
   logic [2:0] s_ref;
   int         s_vin10 = 0;
   int         s_held10 = 0;
   logic       s_cmp;

   nlsar_ctrl #(.CODE_W(2), .REF_W(3)) u_dut_small (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .log_mode_i(1'b1),
      .cmp_ge_i(s_cmp), .sample_o(s_sample), .busy_o(s_busy), .done_o(s_done),
      .code_o(s_code), .dac_ref_o(s_ref));

   always @(posedge clk) if (s_sample) s_held10 <= s_vin10;
   assign s_cmp = (s_held10 >= int'(s_ref) * 10);

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   int exp_ref[256];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rng_of(input int c);
      if (c < 54)  return 1;
      if (c < 102) return 2;
      if (c < 134) return 3;
      if (c < 158) return 4;
      if (c < 188) return 5;
      if (c < 204) return 6;
      if (c < 220) return 7;
      if (c < 232) return 8;
      if (c < 244) return 9;
      return 10;
   endfunction

   function automatic int exp_code(input int v, input bit lg);
      int best = 0;
      for (int c = 0; c < 256; c++) begin
         if ((lg ? exp_ref[c] : 4 * c) <= v) best = c;
      end
      return best;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected done", int'(code), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(code == 8'(e), "R10 result", int'(code), e);
         end
      end
   end

   // one conversion; records the 8 references; optional mode flip / start poke
   task automatic run_conv(input int v, input bit lg, input int flip_at,
                           input int poke_at, output int refs[8]);
      @(negedge clk);
      vin_ana  = v;
      log_mode = lg;
      start    = 1'b1;
      exp_q.push_back(exp_code(v, lg));
      @(negedge clk);
      start = 1'b0;
      chk(sample && busy, "R2 sample cycle", int'(sample), 1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         start = (i == poke_at);
         if (i == flip_at) log_mode = ~log_mode;
         refs[i] = int'(dac_ref);
         chk(busy && !sample && !done, "R3 decision cycle busy", int'(busy), 1);
      end
      @(negedge clk);
      start = 1'b0;
      chk(done && !busy, "R3 done after 9 cycles", int'(done), 1);
   endtask

   initial begin
      #800000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int refs[8];
      int acc;
      int keep_code;
      acc = 0;
      for (int c = 0; c < 256; c++) begin
         exp_ref[c] = acc;
         acc += rng_of(c);
      end

      repeat (3) @(negedge clk);
      chk(!busy && !done && !sample, "R1 reset flags", int'(busy), 0);
      chk(code == 0 && dac_ref == 0, "R1 reset code/ref", int'(code), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4/R5 traced log conversion, input 100 -> 77
      run_conv(100, 1'b1, -1, -1, refs);
      begin
         int want[8] = '{228, 74, 138, 106, 90, 98, 102, 100};
         for (int i = 0; i < 8; i++)
            chk(refs[i] == want[i], "R4 R5 log trial reference", refs[i], want[i]);
      end
      chk(code == 8'd77, "R10 log input 100", int'(code), 77);

      // R4/R6 traced linear conversion with exact-equal hit, input 600 -> 150
      run_conv(600, 1'b0, -1, -1, refs);
      begin
         int want[8] = '{512, 768, 640, 576, 608, 592, 600, 604};
         for (int i = 0; i < 8; i++)
            chk(refs[i] == want[i], "R4 R6 linear trial reference", refs[i], want[i]);
      end
      chk(code == 8'd150, "R6 linear input 600", int'(code), 150);

      // R1: reference idle between conversions
      @(negedge clk);
      chk(dac_ref == 0, "R1 idle reference", int'(dac_ref), 0);

      // R5/R10 log boundaries
      begin
         int vals[7] = '{0, 53, 54, 227, 228, 1013, 1023};
         int wants[7] = '{0, 53, 54, 127, 128, 254, 255};
         foreach (vals[k]) begin
            run_conv(vals[k], 1'b1, -1, -1, refs);
            chk(code == 8'(wants[k]), "R5 log boundary", int'(code), wants[k]);
         end
      end
      chk(exp_ref[255] == 1014, "R5 table top", exp_ref[255], 1014);

      // R6/R10 linear boundaries
      begin
         int vals[4] = '{0, 511, 513, 1023};
         foreach (vals[k]) begin
            run_conv(vals[k], 1'b0, -1, -1, refs);
            chk(code == 8'(vals[k] / 4), "R10 linear boundary", int'(code), vals[k] / 4);
         end
      end

      // R7: mode flipped mid-conversion is ignored
      run_conv(100, 1'b1, 1, -1, refs);
      chk(code == 8'd77, "R7 mode latched", int'(code), 77);
      chk(refs[3] == 106, "R7 log reference kept", refs[3], 106);

      // R8: start while busy ignored
      run_conv(600, 1'b0, -1, 2, refs);
      chk(code == 8'd150, "R8 result unaffected", int'(code), 150);
      keep_code = int'(code);
      repeat (12) begin
         @(negedge clk);
         chk(!busy && !done && !sample, "R8 no second conversion", int'(busy), 0);
      end

      // R9: result held during the next conversion
      @(negedge clk);
      vin_ana  = 300;
      log_mode = 1'b1;
      start    = 1'b1;
      exp_q.push_back(exp_code(300, 1'b1));
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(int'(code) == keep_code, "R9 code held mid conversion", int'(code), keep_code);
      while (!done) @(negedge clk);
      chk(int'(code) == exp_code(300, 1'b1), "R9 code updated at done", int'(code),
          exp_code(300, 1'b1));

      // R11: 2-bit example, input 3.2 steps
      @(negedge clk);
      s_vin10 = 32;
      s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      chk(s_sample == 1'b1, "R11 sample", int'(s_sample), 1);
      @(negedge clk);
      chk(s_ref == 3'd2, "R11 first reference", int'(s_ref), 2);
      @(negedge clk);
      chk(s_ref == 3'd4, "R11 second reference", int'(s_ref), 4);
      @(negedge clk);
      chk(s_done && s_code == 2'd2, "R11 result", int'(s_code), 2);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule